// File: doc/BRIEF.md
# Byte-Addressed Register Access Slave on a Two-Wire Serial Bus

This block lets a two-wire serial bus master (I2C) read and write a small register space of 20 byte locations (00h to 13h). The bus lines are sampled with a much faster system clock, so the block reconstructs the bus events itself. It detects start, repeated start and stop conditions and checks the device address. It then moves bytes through one address pointer that advances by itself. The block pulls SDA low through an open-drain enable and never drives it high.

Toward the register file the block offers a pointer output, one-cycle read and write strobes, write data, and a read data input that is sampled in the strobe cycle. It also has a hold output. The register file uses it to stop copying live time values into the user copy while a transfer works on locations 00h to 07h. A write transaction first sends one pointer byte and then data bytes. A read transaction starts at the current pointer, either after a repeated start or directly. Locations 10h to 12h are reserved.

Top module: `i2c_reg_slave`

## Requirements
- R1: The address byte D0h (device address 68h, write) and D1h (device address 68h, read) are acknowledged. Any other address byte gets no acknowledge. After it, SDA stays released and no strobe occurs until the next START.
- R2: START is a falling SDA while SCL is high, and STOP is a rising SDA while SCL is high. A START or STOP in the middle of a byte drops that byte with no write strobe. A START then starts a fresh address byte.
- R3: In a write transaction, the first byte after the address loads the pointer. A pointer byte of 14h or more loads 00h.
- R4: Each later byte in a write transaction gives exactly one write strobe with the pointer as address and the byte as data, MSB received first. The pointer then increments at the falling edge of that byte's acknowledge clock.
- R5: A read transaction sends the byte at the pointer MSB first. The pointer increments on each ninth clock. If the master acknowledges, the next byte follows. If it does not, SDA stays released until the next START.
- R6: A read transaction started without a pointer write begins at the pointer left by the previous transaction.
- R7: The block acknowledges its address byte, the pointer byte and every data byte by holding SDA low through the whole high period of the ninth clock.
- R8: The pointer wraps from 13h to 00h and never leaves 00h..13h.
- R9: Writes to 10h..12h produce no write strobe. Reads from 10h..12h return 00h whatever the register file supplies.
- R10: The hold output is high while a transaction addressed to this block is open and the pointer is in 00h..07h. It falls at STOP or when the pointer reaches 08h or above.
- R11: During and right after reset, SDA is released, no strobe is active, the hold output is low and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr_o | output | 5 | Current pointer value |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_o |
| reg_rd_o | output | 1 | One-cycle read strobe; reg_rdata_i is sampled in this cycle |
| reg_rdata_i | input | 8 | Read data for reg_addr_o from the register file |
| freeze_o | output | 1 | Hold for the user copy of the time registers |

## Verification
Each bus edge passes two synchronizer stages, so the strobes appear in the second clock after an SCL edge. SDA drive and pointer changes settle by the third. The bench holds every SCL phase for ten clocks and samples the bus only in the middle and on the last clock of a high phase, or half a low phase after a falling edge, which leaves at least two clocks of margin. Write strobes are compared on every clock against a queue of expected address and data pairs that the bench model fills, so a strobe that comes early, late, twice or to a reserved address is caught in the cycle where it appears.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } fsm_e;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_PTR,
    BY_DATA
  } byte_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int unsigned DEPTH   = 20,
  parameter int unsigned RSV_LO  = 16,
  parameter int unsigned RSV_HI  = 18,
  parameter int unsigned FRZ_TOP = 8,
  parameter int unsigned PTR_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [7:0]       load_val_i,
  input  logic             inc_i,
  input  logic             active_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             rsv_o,
  output logic             freeze_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      // out-of-range pointer bytes land on location zero
      ptr_q <= (load_val_i < 8'(DEPTH)) ? load_val_i[PTR_W-1:0] : '0;
    end else if (inc_i) begin
      ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr_o    = ptr_q;
  assign rsv_o    = (ptr_q >= PTR_W'(RSV_LO)) && (ptr_q <= PTR_W'(RSV_HI));
  assign freeze_o = active_i && (ptr_q < PTR_W'(FRZ_TOP));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h68,
  parameter int unsigned DEPTH       = 20,
  parameter int unsigned RSV_LO      = 16,
  parameter int unsigned RSV_HI      = 18,
  parameter int unsigned FRZ_TOP     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PTR_W      = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] reg_addr_o,
  output logic             reg_wr_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_rd_o,
  input  logic [7:0]       reg_rdata_i,
  output logic             freeze_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  // index 0: SCL, index 1: SDA
  logic [1:0] line_raw, line_lvl, line_rise, line_fall;
  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_raw[g]),
      .lvl_o  (line_lvl[g]),
      .rise_o (line_rise[g]),
      .fall_o (line_fall[g])
    );
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  assign scl_s    = line_lvl[0];
  assign sda_s    = line_lvl[1];
  assign scl_rise = line_rise[0];
  assign scl_fall = line_fall[0];
  // SCL high and not just risen means it was high on the previous cycle too
  assign start_det = scl_s && !scl_rise && line_fall[1];
  assign stop_det  = scl_s && !scl_rise && line_rise[1];

  fsm_e             state_q;
  byte_e            kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sh_q, tx_q;
  logic             rw_q, mack_q, active_q, oe_q;

  logic             byte_full, dev_hit, ptr_load, ptr_inc, rsv, idle;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       tx_load;

  assign byte_full = (cnt_q == CNT_W'(BYTE_W));
  assign dev_hit   = (sh_q[7:1] == DEV_ADDR);
  assign idle      = (state_q == ST_IDLE);
  assign tx_load   = rsv ? 8'h00 : reg_rdata_i;

  assign ptr_load = (state_q == ST_RX) && scl_fall && byte_full && (kind_q == BY_PTR);
  assign ptr_inc  = ((state_q == ST_ACK) && scl_fall && (kind_q == BY_DATA)) ||
                    ((state_q == ST_TXACK) && scl_rise);

  assign reg_wr_o    = (state_q == ST_RX) && scl_fall && byte_full &&
                       (kind_q == BY_DATA) && !rsv;
  assign reg_wdata_o = sh_q;
  assign reg_rd_o    = scl_fall && (((state_q == ST_ACK) && (kind_q == BY_ADDR) && rw_q) ||
                                    ((state_q == ST_TXACK) && mack_q));

  i2c_reg_ptr #(
    .DEPTH   (DEPTH),
    .RSV_LO  (RSV_LO),
    .RSV_HI  (RSV_HI),
    .FRZ_TOP (FRZ_TOP),
    .PTR_W   (PTR_W)
  ) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (sh_q),
    .inc_i      (ptr_inc),
    .active_i   (active_q),
    .ptr_o      (ptr),
    .rsv_o      (rsv),
    .freeze_o   (freeze_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      kind_q   <= BY_ADDR;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      active_q <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_RX;
      kind_q  <= BY_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      active_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && !byte_full) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            if (kind_q != BY_ADDR || dev_hit) begin
              oe_q    <= 1'b1;
              state_q <= ST_ACK;
              if (kind_q == BY_ADDR) begin
                active_q <= 1'b1;
                rw_q     <= sh_q[0];
              end
            end else begin
              state_q  <= ST_IDLE;
              active_q <= 1'b0;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (kind_q == BY_ADDR && rw_q) begin
              tx_q    <= tx_load;
              oe_q    <= ~tx_load[7];
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
              kind_q  <= (kind_q == BY_ADDR) ? BY_PTR : BY_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              oe_q    <= 1'b0;
              state_q <= ST_TXACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              oe_q  <= ~tx_q[6];
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_q    <= tx_load;
              oe_q    <= ~tx_load[7];
              cnt_q   <= '0;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o   = oe_q;
  assign reg_addr_o = ptr;
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int unsigned DEPTH   = 20,
  parameter int unsigned RSV_LO  = 16,
  parameter int unsigned RSV_HI  = 18,
  parameter int unsigned FRZ_TOP = 8,
  parameter int unsigned PTR_W   = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_oe_o,
  input logic [PTR_W-1:0] reg_addr_o,
  input logic             reg_wr_o,
  input logic             reg_rd_o,
  input logic             freeze_o,
  input logic             scl_s_i,
  input logic             start_i,
  input logic             stop_i,
  input logic             ptr_load_i,
  input logic             idle_i
);
  AST_WR_NOT_RSV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !(({1'b0, reg_addr_o} >= (PTR_W+1)'(RSV_LO)) &&
                   ({1'b0, reg_addr_o} <= (PTR_W+1)'(RSV_HI)))); // R9

  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o); // R4

  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o); // R5

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, reg_addr_o} < (PTR_W+1)'(DEPTH)); // R8

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(reg_addr_o) == PTR_W'(DEPTH - 1)) && (reg_addr_o != $past(reg_addr_o)) &&
     !$past(ptr_load_i)) |-> (reg_addr_o == '0)); // R8

  AST_FREEZE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_o |-> ({1'b0, reg_addr_o} < (PTR_W+1)'(FRZ_TOP))); // R10

  AST_STOP_UNFREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !freeze_o); // R10

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(start_i) && !$past(stop_i)) |-> !$past(scl_s_i)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !sda_oe_o); // R1
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(
  .DEPTH   (DEPTH),
  .RSV_LO  (RSV_LO),
  .RSV_HI  (RSV_HI),
  .FRZ_TOP (FRZ_TOP),
  .PTR_W   (PTR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_o   (sda_oe_o),
  .reg_addr_o (reg_addr_o),
  .reg_wr_o   (reg_wr_o),
  .reg_rd_o   (reg_rd_o),
  .freeze_o   (freeze_o),
  .scl_s_i    (scl_s),
  .start_i    (start_det),
  .stop_i     (stop_det),
  .ptr_load_i (ptr_load),
  .idle_i     (idle)
);

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, reg_wr, reg_rd, freeze;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire sda_bus = !(m_low || sda_oe);

  logic [7:0] mem [20];
  assign reg_rdata = (reg_addr < 5'd20) ? mem[reg_addr] : 8'h00;

  i2c_reg_slave dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_wr_o    (reg_wr),
    .reg_wdata_o (reg_wdata),
    .reg_rd_o    (reg_rd),
    .reg_rdata_i (reg_rdata),
    .freeze_o    (freeze)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int mptr = 0;
  logic [12:0] wq [$];
  logic [12:0] wexp;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // write strobes compared every clock against the model queue
  always @(negedge clk) begin
    if (rst_n && reg_wr) begin
      if (wq.size() == 0) begin
        check(1'b0, "R4 unexpected write strobe", int'({reg_addr, reg_wdata}), 0);
      end else begin
        wexp = wq.pop_front();
        check({reg_addr, reg_wdata} == wexp, "R4 R9 write strobe addr/data",
              int'({reg_addr, reg_wdata}), int'(wexp));
      end
      if (reg_addr < 5'd20) mem[reg_addr] = reg_wdata;
    end
  end

  function automatic int wrapi(input int p);
    return (p == 19) ? 0 : p + 1;
  endfunction

  function automatic bit rsvd(input int p);
    return (p >= 16) && (p <= 18);
  endfunction

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; clk_n(H/2);
    scl = 1'b1;   clk_n(H);
    m_low = 1'b1; clk_n(H);
    scl = 1'b0;   clk_n(H/2);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; clk_n(H/2);
    scl = 1'b1;   clk_n(H);
    m_low = 1'b0; clk_n(H);
  endtask

  task automatic send_bit(input bit b);
    m_low = !b; clk_n(H/2);
    scl = 1'b1; clk_n(H);
    scl = 1'b0; clk_n(H/2);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    bit a1, a2;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; clk_n(H/2);
    scl = 1'b1;   clk_n(H/2);
    a1 = !sda_bus; clk_n(H/2 - 1);
    a2 = !sda_bus; clk_n(1);
    scl = 1'b0;   clk_n(H/2);
    check(a1 == exp_ack, {tag, " ack mid-high"}, a1, exp_ack);
    check(a2 == exp_ack, {"R7 ack end-high ", tag}, a2, exp_ack);
  endtask

  task automatic wr_data(input logic [7:0] d);
    if (!rsvd(mptr)) wq.push_back({5'(mptr), d});
    send_byte(d, 1'b1, "R4 data byte");
    mptr = wrapi(mptr);
  endtask

  task automatic read_byte(input bit mack, input string tag);
    logic [7:0] v, exp;
    bit rel;
    exp = rsvd(mptr) ? 8'h00 : mem[mptr];
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      clk_n(H/2);
      scl = 1'b1; clk_n(H/2);
      v = {v[6:0], sda_bus}; clk_n(H/2);
      scl = 1'b0;
    end
    clk_n(H/2);
    m_low = mack; clk_n(H/2);
    scl = 1'b1;   clk_n(H/2);
    rel = sda_bus; clk_n(H/2);
    scl = 1'b0;   clk_n(H/2);
    m_low = 1'b0;
    check(v == exp, tag, v, exp);
    mptr = wrapi(mptr);
    if (!mack) begin
      check(rel == 1'b1, "R5 slave released on nack bit", rel, 1);
      clk_n(H/2);
      check(sda_oe == 1'b0, "R5 slave quiet after nack", sda_oe, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 20; i++) mem[i] = 8'h80 | 8'(i);
    clk_n(5);
    // R11 reset state
    check(sda_oe == 1'b0, "R11 sda released in reset", sda_oe, 0);
    check(reg_wr == 1'b0 && reg_rd == 1'b0, "R11 no strobe in reset", {reg_wr, reg_rd}, 0);
    check(freeze == 1'b0, "R11 freeze low in reset", freeze, 0);
    check(reg_addr == 5'd0, "R11 pointer zero in reset", reg_addr, 0);
    rst_n = 1'b1;
    clk_n(5);
    check(sda_oe == 1'b0 && freeze == 1'b0, "R11 quiet after reset", {sda_oe, freeze}, 0);

    // write 5..7, hold drops when pointer reaches 08h
    bus_start();
    send_byte(8'hD0, 1'b1, "R1 write address");
    send_byte(8'h05, 1'b1, "R3 pointer byte");
    mptr = 5;
    check(freeze == 1'b1, "R10 hold at pointer 05h", freeze, 1);
    wr_data(8'h11);
    wr_data(8'h22);
    check(freeze == 1'b1, "R10 hold at pointer 07h", freeze, 1);
    wr_data(8'h33);
    check(freeze == 1'b0, "R10 hold released at 08h", freeze, 0);
    check(reg_addr == 5'd8, "R4 pointer advanced to 08h", reg_addr, 8);
    bus_stop();

    // across reserved locations and the wrap
    bus_start();
    send_byte(8'hD0, 1'b1, "R1 write address");
    send_byte(8'h0F, 1'b1, "R3 pointer byte 0Fh");
    mptr = 15;
    check(freeze == 1'b0, "R10 no hold at 0Fh", freeze, 0);
    wr_data(8'hA5);
    wr_data(8'hE1);
    wr_data(8'hE2);
    wr_data(8'hE3);
    check(reg_addr == 5'd19, "R9 pointer still advances over reserved", reg_addr, 19);
    wr_data(8'h5A);
    check(reg_addr == 5'd0, "R8 wrap 13h to 00h", reg_addr, 0);
    wr_data(8'hC3);
    wr_data(8'h3C);
    check(freeze == 1'b1, "R10 hold after wrap", freeze, 1);
    bus_stop();
    check(freeze == 1'b0, "R10 hold released at stop", freeze, 0);

    // random read across reserved and wrap
    bus_start();
    send_byte(8'hD0, 1'b1, "R1 write address");
    send_byte(8'h12, 1'b1, "R3 pointer byte 12h");
    mptr = 18;
    bus_start();
    send_byte(8'hD1, 1'b1, "R1 read address");
    read_byte(1'b1, "R9 reserved read returns 00h");
    read_byte(1'b1, "R5 read 13h");
    read_byte(1'b0, "R8 read after wrap 00h");
    check(freeze == 1'b1, "R10 hold after nack before stop", freeze, 1);
    bus_stop();
    check(freeze == 1'b0, "R10 hold released at stop", freeze, 0);

    // current-address read
    bus_start();
    send_byte(8'hD1, 1'b1, "R6 read address");
    read_byte(1'b1, "R6 read from kept pointer");
    read_byte(1'b0, "R6 second byte");
    bus_stop();
    check(reg_addr == 5'd3, "R5 pointer after read", reg_addr, 3);

    // wrong addresses
    bus_start();
    send_byte(8'hA0, 1'b0, "R1 foreign address");
    send_byte(8'hFF, 1'b0, "R1 ignored byte");
    check(sda_oe == 1'b0 && freeze == 1'b0, "R1 quiet after foreign address", {sda_oe, freeze}, 0);
    bus_stop();
    bus_start();
    send_byte(8'hD3, 1'b0, "R1 foreign read address");
    bus_stop();
    check(reg_addr == 5'd3, "R1 pointer untouched", reg_addr, 3);

    // stop in the middle of a data byte
    bus_start();
    send_byte(8'hD0, 1'b1, "R1 write address");
    send_byte(8'h04, 1'b1, "R3 pointer byte 04h");
    mptr = 4;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    check(wq.size() == 0 && reg_addr == 5'd4, "R2 stop drops partial byte",
          reg_addr, 4);
    check(freeze == 1'b0, "R2 R10 hold low after mid-byte stop", freeze, 0);

    // start in the middle of a data byte
    bus_start();
    send_byte(8'hD0, 1'b1, "R1 write address");
    send_byte(8'h09, 1'b1, "R3 pointer byte 09h");
    mptr = 9;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(8'hD1, 1'b1, "R2 address after mid-byte start");
    read_byte(1'b0, "R2 read after aborted byte");
    bus_stop();

    // pointer byte out of range
    bus_start();
    send_byte(8'hD0, 1'b1, "R1 write address");
    send_byte(8'h30, 1'b1, "R3 pointer byte 30h");
    mptr = 0;
    check(reg_addr == 5'd0, "R3 out-of-range pointer loads 00h", reg_addr, 0);
    bus_start();
    send_byte(8'hD1, 1'b1, "R1 read address");
    read_byte(1'b0, "R3 read at 00h");
    bus_stop();

    clk_n(4);
    check(wq.size() == 0, "R4 all expected writes seen", wq.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule